// File: doc/BRIEF.md
# SMBus Special Address Filter and Clock-Low Timeout Monitor

This block sits next to an I2C byte engine and decides whether a received 7-bit address should be acknowledged. The engine supplies its own ordinary address match. When SMBus operation is switched on, this block can also claim three reserved SMBus addresses. Which of them it claims depends on a device/host type bit, an address-resolution enable and an alert enable. With SMBus operation switched off, only the ordinary match counts, so the block acts as plain I2C.

The block also runs a clock-low monitor. It counts prescaled time-base ticks while the sampled SCL level is low. If the line stays low past a parameterised limit, nominally 35 ms expressed in ticks, it sets a sticky timeout flag. The flag stays set until it is cleared by a pulse.

Top module: `smb_addr_tmo`

## Requirements
- R1: With `smb_en` low, `ack` equals the registered ordinary match only. No special address is acknowledged, and the timeout flag never sets.
- R2: The device default address 7'b1100001 is acknowledged only when `smb_en`, `arp_en` and `smb_en` are high and `host_sel` is 0.
- R3: The host header address 7'b0001000 is acknowledged only when `smb_en` and `arp_en` are high and `host_sel` is 1.
- R4: The alert response address 7'b0001100 is acknowledged when `smb_en` and `alert_en` are high, whatever `host_sel` and `arp_en` are.
- R5: `ack` is the OR of `own_match` and any enabled special match. It is registered on the clock edge where `addr_vld` is high, and it holds until the next strobe.
- R6: The low counter counts ticks while `scl_in` is 0 and returns to zero on any cycle where `scl_in` is 1.
- R7: `tmo_flag` sets on the tick that brings the low count to `TMO_TICKS`. It fires once per low period and does not retrigger on later ticks.
- R8: `tmo_flag` is sticky and is cleared only by `tmo_clr`. Reset leaves `ack` and `tmo_flag` at 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| smb_en | input | 1 | SMBus operation enable |
| host_sel | input | 1 | Type: 0 device, 1 host |
| arp_en | input | 1 | Address-resolution enable |
| alert_en | input | 1 | Alert response enable |
| addr | input | 7 | Received address |
| addr_vld | input | 1 | Address valid strobe |
| own_match | input | 1 | Ordinary own-address match from the engine |
| ack | output | 1 | Registered acknowledge decision |
| scl_in | input | 1 | Sampled SCL level |
| tick | input | 1 | Time-base tick |
| tmo_clr | input | 1 | Clear pulse for the timeout flag |
| tmo_flag | output | 1 | Sticky clock-low timeout flag |

## Verification
The hardest case to reach is a clock-low period that runs past the limit. The flag must set exactly once, must ignore the extra ticks that follow, and must be cleared while SCL is still low without setting again. The bench reaches this by holding SCL low for a counted number of ticks, with a small `TMO_TICKS`. It also pulses the clear in the middle of the overrun, then releases SCL for random low periods. Address decisions come from random configurations mixed with the three reserved addresses.

// File: rtl/smb_addr_tmo.sv
module smb_addr_tmo #(
  parameter int TMO_TICKS = 35000,
  parameter logic [6:0] DEV_ADDR   = 7'b1100001,
  parameter logic [6:0] HOST_ADDR  = 7'b0001000,
  parameter logic [6:0] ALERT_ADDR = 7'b0001100
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       smb_en,
  input  logic       host_sel,
  input  logic       arp_en,
  input  logic       alert_en,
  input  logic [6:0] addr,
  input  logic       addr_vld,
  input  logic       own_match,
  output logic       ack,
  input  logic       scl_in,
  input  logic       tick,
  input  logic       tmo_clr,
  output logic       tmo_flag
);
  localparam int CW = $clog2(TMO_TICKS + 1);

  logic hit_dev, hit_host, hit_alert, ack_nxt;
  logic [CW-1:0] low_cnt;
  logic at_lim;

  assign hit_dev   = smb_en & arp_en & ~host_sel & (addr == DEV_ADDR);
  assign hit_host  = smb_en & arp_en &  host_sel & (addr == HOST_ADDR);
  assign hit_alert = smb_en & alert_en & (addr == ALERT_ADDR);
  assign ack_nxt   = own_match | hit_dev | hit_host | hit_alert;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n)        ack <= 1'b0;
    else if (addr_vld) ack <= ack_nxt;

  assign at_lim = (low_cnt == CW'(TMO_TICKS));

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n)                              low_cnt <= '0;
    else if (scl_in || !smb_en)              low_cnt <= '0;
    else if (tick && !at_lim)                low_cnt <= low_cnt + 1'b1;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n)       tmo_flag <= 1'b0;
    else if (tmo_clr) tmo_flag <= 1'b0;
    else if (smb_en && !scl_in && tick && low_cnt == CW'(TMO_TICKS - 1))
      tmo_flag <= 1'b1;

  AST_ACK_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !addr_vld |=> $stable(ack)); // R5
  AST_OWN_ACK: assert property (@(posedge clk) disable iff (!rst_n)
    (addr_vld && own_match) |=> ack); // R5
  AST_PLAIN_I2C: assert property (@(posedge clk) disable iff (!rst_n)
    (addr_vld && !smb_en) |=> (ack == $past(own_match))); // R1
  AST_CNT_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    scl_in |=> (low_cnt == '0)); // R6
  AST_CNT_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    low_cnt <= CW'(TMO_TICKS)); // R7
  AST_FLAG_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    (tmo_flag && !tmo_clr) |=> tmo_flag); // R8
  AST_FLAG_CLR: assert property (@(posedge clk) disable iff (!rst_n)
    tmo_clr |=> !tmo_flag); // R8
  AST_NO_RETRIG: assert property (@(posedge clk) disable iff (!rst_n)
    (at_lim && !scl_in && smb_en) |=> !$rose(tmo_flag)); // R7
endmodule

// File: tb/smb_addr_tmo_tb.sv
module smb_addr_tmo_tb_top;
  localparam int LIM = 12;
  logic clk = 0, rst_n = 0;
  logic smb_en = 0, host_sel = 0, arp_en = 0, alert_en = 0;
  logic [6:0] addr = 0;
  logic addr_vld = 0, own_match = 0, scl_in = 1, tick = 0, tmo_clr = 0;
  logic ack, tmo_flag;
  int checks = 0, errors = 0;

  always #2.5 clk = ~clk;

  smb_addr_tmo #(.TMO_TICKS(LIM)) dut_i (.*);

  function automatic logic exp_ack(logic se, logic hs, logic ae, logic al,
                                   logic [6:0] a, logic om);
    logic r;
    r = om;
    if (se && ae && !hs && a == 7'b1100001) r = 1;
    if (se && ae &&  hs && a == 7'b0001000) r = 1;
    if (se && al && a == 7'b0001100) r = 1;
    return r;
  endfunction

  task automatic chk(string req, logic act, logic exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0b expected=%0b", req, act, exp);
    end
  endtask

  task automatic addr_try(logic se, logic hs, logic ae, logic al,
                          logic [6:0] a, logic om, string req);
    @(negedge clk);
    smb_en = se; host_sel = hs; arp_en = ae; alert_en = al;
    addr = a; own_match = om; addr_vld = 1;
    @(negedge clk);
    addr_vld = 0;
    chk(req, ack, exp_ack(se, hs, ae, al, a, om));
    addr = ~a;
    own_match = ~om;
    @(negedge clk);
    chk({req, " hold"}, ack, exp_ack(se, hs, ae, al, a, om));
  endtask

  task automatic ticks(int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk); tick = 1;
      @(negedge clk); tick = 0;
    end
  endtask

  initial begin
    #200000;
    errors++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    void'($urandom(32'd1234));
    repeat (3) @(negedge clk);
    chk("R8 reset ack", ack, 0);
    chk("R8 reset flag", tmo_flag, 0);
    rst_n = 1;

    addr_try(1, 0, 1, 0, 7'b1100001, 0, "R2 dev ack");
    addr_try(1, 1, 1, 0, 7'b1100001, 0, "R2 dev host_sel");
    addr_try(1, 0, 0, 0, 7'b1100001, 0, "R2 dev no arp");
    addr_try(1, 1, 1, 0, 7'b0001000, 0, "R3 host ack");
    addr_try(1, 0, 1, 0, 7'b0001000, 0, "R3 host dev type");
    addr_try(1, 0, 0, 1, 7'b0001100, 0, "R4 alert dev");
    addr_try(1, 1, 0, 1, 7'b0001100, 0, "R4 alert host");
    addr_try(1, 1, 1, 0, 7'b0001100, 0, "R4 alert off");
    addr_try(0, 0, 1, 1, 7'b1100001, 0, "R1 plain dev");
    addr_try(0, 1, 1, 1, 7'b0001100, 1, "R1 plain own");
    addr_try(1, 0, 0, 0, 7'b0101010, 1, "R5 own");

    for (int i = 0; i < 60; i++) begin
      logic [6:0] a;
      case ($urandom_range(0, 3))
        0: a = 7'b1100001;
        1: a = 7'b0001000;
        2: a = 7'b0001100;
        default: a = 7'($urandom);
      endcase
      addr_try(1'($urandom), 1'($urandom), 1'($urandom), 1'($urandom),
               a, 1'($urandom), "R5 random");
    end

    smb_en = 1;
    @(negedge clk); scl_in = 0;
    ticks(LIM - 1);
    chk("R7 below limit", tmo_flag, 0);
    ticks(1);
    chk("R7 at limit", tmo_flag, 1);
    ticks(2);
    @(negedge clk); tmo_clr = 1;
    @(negedge clk); tmo_clr = 0;
    chk("R8 clear", tmo_flag, 0);
    ticks(5);
    chk("R7 no retrigger", tmo_flag, 0);

    @(negedge clk); scl_in = 1;
    @(negedge clk); scl_in = 0;
    ticks(LIM - 1);
    @(negedge clk); scl_in = 1;
    @(negedge clk); scl_in = 0;
    ticks(LIM - 1);
    chk("R6 high resets count", tmo_flag, 0);
    ticks(1);
    chk("R6 count restart", tmo_flag, 1);
    @(negedge clk); scl_in = 1;
    ticks(3);
    chk("R8 sticky", tmo_flag, 1);
    @(negedge clk); tmo_clr = 1;
    @(negedge clk); tmo_clr = 0;

    for (int i = 0; i < 20; i++) begin
      int n;
      n = $urandom_range(1, LIM + 3);
      @(negedge clk); scl_in = 0;
      ticks(n);
      chk("R7 random low", tmo_flag, n >= LIM);
      @(negedge clk); scl_in = 1; tmo_clr = 1;
      @(negedge clk); tmo_clr = 0;
    end

    smb_en = 0;
    @(negedge clk); scl_in = 0;
    ticks(LIM + 4);
    chk("R1 no timeout", tmo_flag, 0);
    scl_in = 1;

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule